// File: doc/BRIEF.md
# Safe FIFO Drain Sequencer

This block runs on the host side of a link to a remote receiver whose byte FIFO can only be reached through a register-read port. Given a packet length and a start strobe, it drains that one packet from the remote FIFO. While it does so, it never lets the FIFO run dry when packet bytes are still to arrive.

The block works in rounds. In each round it reads the remote byte-count register over and over. It trusts a count only when two successive reads in that round return the same value. If the trusted count is smaller than the number of bytes still owed, the block pops one byte fewer than the count and starts a new round. If the count equals the bytes still owed, the whole packet has landed, so the block pops every remaining byte and finishes.

Each popped byte is presented with a one-cycle valid strobe. A one-cycle done pulse follows the final byte. A count that never settles, or a count larger than the bytes still owed, stops the block with an error flag. The next start clears that flag.

Top module: `fdr_drain_seq`

## Requirements
- R1: After reset, `rd_req`, `out_valid`, `done` and `err` are all low, and no read is issued until `start` is seen.
- R2: Every read is a one-cycle `rd_req` pulse. No new request is issued before the response (`rd_valid`) to the previous one arrives. Count reads use address `COUNT_ADDR` (default 0) and FIFO reads use `FIFO_ADDR` (default 1).
- R3: A count value is trusted only when two successive count reads in the same round are equal. A value that differs from the one before it becomes the new reference. For example, if the first read of a round is corrupted, the round takes three reads.
- R4: When the trusted count n is below the bytes still owed, exactly n-1 FIFO reads follow (none when n is 0 or 1), and then a new round begins. The remote FIFO therefore never becomes empty before the whole packet has arrived.
- R5: When the trusted count equals the bytes still owed, all remaining bytes are popped with no further count reads. For a packet fully present at start, this takes exactly two count reads.
- R6: Each FIFO response appears on `out_data` with `out_valid` high for one cycle, in the cycle after `rd_valid`. Bytes leave in the order the FIFO returned them.
- R7: `done` is high for exactly one cycle, in the cycle after the final byte's `out_valid`. A packet length of 0 produces `done` with no read at all.
- R8: If `MAX_READS` (default 6) count reads in one round contain no two equal successive values, `err` is raised. No further request is issued and `done` stays low.
- R9: A trusted count larger than the bytes still owed raises `err` before any FIFO read of that round.
- R10: `err` holds until the next `start`, which clears it and begins a new drain.
- R11: `start` is ignored while a drain is in progress. The running packet completes with its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin draining one packet |
| pkt_len | input | LEN_W | Packet length in bytes, sampled with `start` |
| rd_req | output | 1 | Read request pulse to the remote register port |
| rd_addr | output | ADDR_W | Register address for the request |
| rd_data | input | DATA_W | Read response data |
| rd_valid | input | 1 | Read response strobe |
| out_data | output | DATA_W | Drained packet byte |
| out_valid | output | 1 | One-cycle strobe for `out_data` |
| done | output | 1 | One-cycle pulse after the final byte |
| err | output | 1 | Sticky error: count did not settle, or count exceeded bytes owed |

## Verification
The embedded assertions watch the following on every cycle:
- each request lasts a single cycle;
- a FIFO read is only issued inside a budget that is non-zero and no larger than the bytes still owed;
- every final byte is followed by `done`;
- an over-large count leads at once to a flagged halt;
- the per-round read counter stays within its limit.

The directed scenarios show the rest, using a behavioural remote FIFO that counts its own reads and flags any moment it is emptied early:
- the value rules that decide when a count is trusted, such as a single corrupted read or a count that keeps flipping;
- the exact n-1 budget while arrivals are frozen;
- byte order across the whole packet;
- recovery from an error.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_POLL_REQ,
    S_POLL_WAIT,
    S_POP_REQ,
    S_POP_WAIT,
    S_FIN,
    S_FAULT
  } fdr_state_e;

  typedef enum logic [1:0] {
    V_POP_ALL,
    V_POP_PART,
    V_OVERRUN
  } fdr_verdict_e;

  // Classify a trusted count against the bytes still owed.
  function automatic fdr_verdict_e fdr_classify(input int unsigned n,
                                                input int unsigned owed);
    if (n > owed)       return V_OVERRUN;
    else if (n == owed) return V_POP_ALL;
    else                return V_POP_PART;
  endfunction

  // Safe partial pop count: leave one byte behind.
  function automatic int unsigned fdr_part_pops(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

endpackage

// File: rtl/fdr_stable_det.sv
module fdr_stable_det #(
  parameter int DATA_W    = 8,
  parameter int MAX_READS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp,
  output logic              stable,
  output logic              timeout
);
  localparam int RW = $clog2(MAX_READS + 2);

  logic              have_prev_q;
  logic [DATA_W-1:0] prev_q;
  logic [RW-1:0]     reads_q;
  logic [RW-1:0]     reads_next;

  assign reads_next = reads_q + 1'b1;
  assign stable     = smp_valid && have_prev_q && (smp == prev_q);
  assign timeout    = smp_valid && !stable && (reads_next >= RW'(MAX_READS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_q      <= '0;
      reads_q     <= '0;
    end else if (clear) begin
      have_prev_q <= 1'b0;
      reads_q     <= '0;
    end else if (smp_valid) begin
      have_prev_q <= 1'b1;
      prev_q      <= smp;
      if (reads_q < RW'(MAX_READS)) reads_q <= reads_next;
    end
  end

  assert_read_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reads_q <= RW'(MAX_READS));

  assert_stable_needs_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stable |-> (reads_q != '0));

endmodule

// File: rtl/fdr_budget.sv
module fdr_budget
  import fdr_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] n,
  input  logic [LEN_W-1:0]  owed,
  output fdr_verdict_e      verdict,
  output logic [LEN_W-1:0]  pops
);
  int unsigned n_u;
  int unsigned owed_u;
  int unsigned pops_u;

  always_comb begin
    n_u     = 32'(n);
    owed_u  = 32'(owed);
    verdict = fdr_classify(n_u, owed_u);
    pops_u  = (verdict == V_POP_ALL) ? owed_u : fdr_part_pops(n_u);
    pops    = LEN_W'(pops_u);
  end

endmodule

// File: rtl/fdr_drain_seq.sv
module fdr_drain_seq
  import fdr_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 4,
  parameter int COUNT_ADDR = 0,
  parameter int FIFO_ADDR  = 1,
  parameter int MAX_READS  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              done,
  output logic              err
);

  fdr_state_e        state_q;
  logic [LEN_W-1:0]  owed_q;
  logic [LEN_W-1:0]  pop_left_q;
  logic [DATA_W-1:0] out_data_q;
  logic              out_valid_q;
  logic              done_q;
  logic              err_q;

  // Named internal events
  logic         start_ok;
  logic         count_resp;
  logic         byte_resp;
  logic         cnt_stable;
  logic         cnt_timeout;
  logic         det_clear;
  logic         overrun_hit;
  fdr_verdict_e verdict;
  logic [LEN_W-1:0] budget_pops;

  assign start_ok   = start && (state_q == S_IDLE || state_q == S_FAULT);
  assign count_resp = (state_q == S_POLL_WAIT) && rd_valid;
  assign byte_resp  = (state_q == S_POP_WAIT) && rd_valid;
  assign det_clear  = !(state_q == S_POLL_REQ || state_q == S_POLL_WAIT)
                      || (count_resp && cnt_stable);
  assign overrun_hit = count_resp && cnt_stable && (verdict == V_OVERRUN);

  fdr_stable_det #(
    .DATA_W    (DATA_W),
    .MAX_READS (MAX_READS)
  ) u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (det_clear),
    .smp_valid (count_resp),
    .smp       (rd_data),
    .stable    (cnt_stable),
    .timeout   (cnt_timeout)
  );

  fdr_budget #(
    .LEN_W  (LEN_W),
    .DATA_W (DATA_W)
  ) u_budget (
    .n       (rd_data),
    .owed    (owed_q),
    .verdict (verdict),
    .pops    (budget_pops)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      owed_q      <= '0;
      pop_left_q  <= '0;
      out_data_q  <= '0;
      out_valid_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      out_valid_q <= 1'b0;
      done_q      <= 1'b0;
      case (state_q)
        S_IDLE, S_FAULT: begin
          if (start_ok) begin
            err_q   <= 1'b0;
            owed_q  <= pkt_len;
            state_q <= (pkt_len == '0) ? S_FIN : S_POLL_REQ;
          end
        end
        S_POLL_REQ: state_q <= S_POLL_WAIT;
        S_POLL_WAIT: begin
          if (count_resp) begin
            if (cnt_stable) begin
              if (verdict == V_OVERRUN) begin
                err_q   <= 1'b1;
                state_q <= S_FAULT;
              end else begin
                pop_left_q <= budget_pops;
                state_q    <= (budget_pops == '0) ? S_POLL_REQ : S_POP_REQ;
              end
            end else if (cnt_timeout) begin
              err_q   <= 1'b1;
              state_q <= S_FAULT;
            end else begin
              state_q <= S_POLL_REQ;
            end
          end
        end
        S_POP_REQ: state_q <= S_POP_WAIT;
        S_POP_WAIT: begin
          if (byte_resp) begin
            out_valid_q <= 1'b1;
            out_data_q  <= rd_data;
            owed_q      <= owed_q - 1'b1;
            pop_left_q  <= pop_left_q - 1'b1;
            if (pop_left_q == LEN_W'(1))
              state_q <= (owed_q == LEN_W'(1)) ? S_FIN : S_POLL_REQ;
            else
              state_q <= S_POP_REQ;
          end
        end
        S_FIN: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req    = (state_q == S_POLL_REQ) || (state_q == S_POP_REQ);
  assign rd_addr   = (state_q == S_POP_REQ) ? ADDR_W'(FIFO_ADDR) : ADDR_W'(COUNT_ADDR);
  assign out_data  = out_data_q;
  assign out_valid = out_valid_q;
  assign done      = done_q;
  assign err       = err_q;

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_pop_in_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_addr == ADDR_W'(FIFO_ADDR)) |-> (pop_left_q != '0 && pop_left_q <= owed_q));

  assert_byte_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && owed_q == '0) |=> done);

  assert_halt_on_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!rd_req && !done));

  assert_overrun_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_hit |=> (err && !rd_req));

endmodule

// File: tb/fdr_drain_seq_tb.sv
module fdr_drain_seq_tb;

  localparam int LEN_W = 8, DW = 8, AW = 4, MAXR = 6;
  localparam int CADDR = 0, FADDR = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic rd_req;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic rd_valid = 1'b0;
  logic [DW-1:0] out_data;
  logic out_valid, done, err;

  always #4 clk = ~clk;

  fdr_drain_seq #(.LEN_W(LEN_W), .DATA_W(DW), .ADDR_W(AW), .COUNT_ADDR(CADDR),
                  .FIFO_ADDR(FADDR), .MAX_READS(MAXR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_len(pkt_len),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .out_data(out_data), .out_valid(out_valid), .done(done), .err(err));

  // Remote FIFO model state
  logic [7:0] mq [0:255];
  int head, tail, total, arrived, gap, gap_cnt, lat, glitch_idx, base, cur_len;
  bit flap, hold_arr;
  int cnt_reads, fifo_reads, bytes_seen, done_seen, early_empty, underflow, mismatch, done_bad;
  bit pend, prev_ov;
  int pend_wait, pend_addr;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int tot, input int pre, input int g, input int l,
                     input int gl, input bit fl, input int b);
    head = 0; tail = 0; arrived = 0; total = tot; gap = g; gap_cnt = g; lat = l;
    glitch_idx = gl; flap = fl; base = b; hold_arr = 0;
    cnt_reads = 0; fifo_reads = 0; bytes_seen = 0; done_seen = 0;
    early_empty = 0; underflow = 0; mismatch = 0; done_bad = 0;
    for (int i = 0; i < pre; i++) begin
      mq[tail % 256] = 8'(base + arrived); tail++; arrived++;
    end
  endtask

  task automatic model_step();
    int v;
    rd_valid = 1'b0;
    if (pend) begin
      if (pend_wait > 0) pend_wait--;
      else begin
        pend = 0;
        if (pend_addr == CADDR) begin
          cnt_reads++;
          v = tail - head;
          if (flap) v = (cnt_reads % 2) ? 3 : 4;
          else if (cnt_reads == glitch_idx) v = v ^ 8'h5A;
          rd_data = 8'(v);
        end else begin
          fifo_reads++;
          if (head == tail) begin underflow++; rd_data = '0; end
          else begin rd_data = mq[head % 256]; head++; end
          if (head == tail && arrived < total) early_empty++;
        end
        rd_valid = 1'b1;
      end
    end
    if (rd_req) begin pend = 1; pend_addr = int'(rd_addr); pend_wait = lat; end
    if (!hold_arr && arrived < total) begin
      if (gap_cnt == 0) begin
        mq[tail % 256] = 8'(base + arrived); tail++; arrived++; gap_cnt = gap;
      end else gap_cnt--;
    end
    if (out_valid) begin
      if (out_data != 8'(base + bytes_seen)) mismatch++;
      bytes_seen++;
    end
    if (done) begin
      done_seen++;
      if (cur_len > 0 && !prev_ov) done_bad++;
    end
    prev_ov = out_valid;
  endtask

  initial begin
    pend = 0; prev_ov = 0;
    cfg(0, 0, 100, 0, 0, 0, 0);
    forever begin
      @(negedge clk);
      if (rst_n) model_step();
    end
  end

  task automatic go(input int len);
    @(posedge clk); #2;
    cur_len = len; start = 1'b1; pkt_len = LEN_W'(len);
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_end();
    for (int c = 0; c < 4000 && done_seen == 0 && !err; c++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 rd_req", int'(rd_req), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
  endtask

  task automatic t_preload();
    @(posedge clk); #1; cfg(6, 6, 1000, 0, 0, 0, 8'h10);
    go(6); wait_end();
    chk("R5 count reads", cnt_reads, 2);
    chk("R5 fifo reads", fifo_reads, 6);
    chk("R6 bytes", bytes_seen, 6);
    chk("R6 order", mismatch, 0);
    chk("R7 done once", done_seen, 1);
    chk("R7 done timing", done_bad, 0);
  endtask

  task automatic t_glitch();
    @(posedge clk); #1; cfg(5, 5, 1000, 0, 1, 0, 8'h40);
    go(5); wait_end();
    chk("R3 reads after glitch", cnt_reads, 3);
    chk("R3 bytes", bytes_seen, 5);
    chk("R3 order", mismatch, 0);
  endtask

  task automatic t_stream(input int len, input int g, input int l, input int gl);
    @(posedge clk); #1; cfg(len, 0, g, l, gl, 0, 8'h80);
    go(len); wait_end();
    chk("R4 early empty", early_empty, 0);
    chk("R4 underflow", underflow, 0);
    chk("R6 stream bytes", bytes_seen, len);
    chk("R6 stream order", mismatch, 0);
    chk("R7 stream done", done_seen, 1);
    chk("R2 rounds", int'(cnt_reads > 2), 1);
  endtask

  task automatic t_partial();
    @(posedge clk); #1; cfg(10, 4, 3, 0, 0, 0, 8'h20); hold_arr = 1;
    go(10);
    repeat (80) @(negedge clk);
    chk("R4 partial pops", bytes_seen, 3);
    chk("R4 partial fifo reads", fifo_reads, 3);
    chk("R4 no done yet", done_seen, 0);
    @(posedge clk); #1; hold_arr = 0;
    wait_end();
    chk("R4 partial finish", bytes_seen, 10);
    chk("R4 partial early empty", early_empty, 0);
  endtask

  task automatic t_flap();
    @(posedge clk); #1; cfg(5, 0, 1000, 0, 0, 1, 0);
    go(5); wait_end();
    chk("R8 err", int'(err), 1);
    chk("R8 reads", cnt_reads, MAXR);
    repeat (20) @(negedge clk);
    chk("R8 halted", cnt_reads + fifo_reads, MAXR);
    chk("R8 no done", done_seen, 0);
  endtask

  task automatic t_overrun();
    @(posedge clk); #1; cfg(9, 9, 1000, 0, 0, 0, 0);
    go(5); wait_end();
    chk("R9 err", int'(err), 1);
    chk("R9 no fifo read", fifo_reads, 0);
    chk("R9 no bytes", bytes_seen, 0);
    @(posedge clk); #1; cfg(4, 4, 1000, 0, 0, 0, 8'h60);
    go(4);
    @(negedge clk);
    chk("R10 err cleared", int'(err), 0);
    wait_end();
    chk("R10 recovered bytes", bytes_seen, 4);
    chk("R10 recovered done", done_seen, 1);
  endtask

  task automatic t_zero();
    @(posedge clk); #1; cfg(0, 0, 1000, 0, 0, 0, 0);
    go(0); repeat (5) @(negedge clk);
    chk("R7 zero done", done_seen, 1);
    chk("R7 zero reads", cnt_reads + fifo_reads, 0);
  endtask

  task automatic t_busy();
    @(posedge clk); #1; cfg(8, 0, 6, 0, 0, 0, 8'hA0);
    go(8);
    repeat (10) @(posedge clk);
    #2; start = 1'b1; pkt_len = LEN_W'(3);
    @(posedge clk); #2; start = 1'b0;
    wait_end();
    chk("R11 length kept", bytes_seen, 8);
    chk("R11 order", mismatch, 0);
    chk("R11 done", done_seen, 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_preload();
    t_glitch();
    t_stream(24, 6, 0, 0);
    t_stream(16, 10, 2, 4);
    t_partial();
    t_flap();
    t_overrun();
    t_zero();
    t_busy();
    summary();
  end

endmodule